// File: doc/BRIEF.md
# Regulator Turn-On Sequencer and Undervoltage Interrupt Controller

This block is the digital control slice for three step-down regulators. For each channel it takes a start request and holds the regulator enable off for a programmed number of millisecond ticks. The wait is picked by a 3-bit code whose non-zero values give power-of-two waits of 2 to 128 ms, and whose zero value gives no wait at all. A free-running 1 ms tick from elsewhere on the chip drives the count.

Each channel also reports a live power-good bit. That bit is derived from the channel's enable and from an undervoltage flag supplied by an external comparator. If the channel's fault mask-enable bit is set and an enabled channel drops out of regulation, the block latches a per-channel fault flag and pulls a shared active-low interrupt. A flag is released only when the host reads that channel's status word through a simple register read port, which stands in for the serial host bus. A per-channel forced fixed-frequency mode bit is stored and passed straight out to the regulator.

Top module: `pwr_seq_irq_ctrl`

## Requirements
- R1: After synchronous reset, every enable output is low, irq_n is high, force_pwm is zero, and every address reads back as zero.
- R2: With a non-zero code c, the enable rises in the cycle after the clock edge that samples the 2^c-th tick counted while the start request is held. Ticks are counted from the first cycle of the request. Once risen, the enable is not affected by later code changes.
- R3: With code 0, the enable follows the start request combinationally, in the same cycle.
- R4: Dropping a start request drives that channel's enable low in the same cycle. The pending count is discarded, so the next request waits the full time again.
- R5: A channel's fault flag is set at a clock edge where its undervoltage flag is high, its enable is high and its mask-enable bit is 1. A channel with the mask bit at 0, or with its enable low, never sets its flag.
- R6: irq_n is low exactly while at least one channel's fault flag is set. It goes low in the cycle after the causing edge.
- R7: A read strobe on channel i's address clears only flag i at that edge, with priority over setting it. If the fault condition persists, the flag sets again on the next edge.
- R8: Read data bit 0 is the live status of the addressed channel: 1 when its enable is high and its undervoltage flag is low, otherwise 0.
- R9: Addresses 0 to 2 select channels 0 to 2. Within a channel word, bits 3:1 hold the delay code, bit 4 the mask-enable and bit 5 the mode, and all of these are written by a write strobe. Bits 7:6 read zero and bit 0 is not writable. Address 3 reads zero and ignores writes.
- R10: force_pwm[i] equals channel i's stored mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| start_req | input | 3 | Per-channel turn-on request |
| uv_flag | input | 3 | Per-channel undervoltage flag from the comparator, synchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (channel index) |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe; clears the addressed channel's fault flag |
| rd_addr | input | 2 | Read address (channel index) |
| rd_data | output | 8 | Read data for rd_addr, combinational |
| reg_en | output | 3 | Per-channel regulator enable |
| force_pwm | output | 3 | Per-channel forced fixed-frequency mode |
| irq_n | output | 1 | Active-low fault interrupt |

## Verification
A wrong tick count or a stale done state shows up on reg_en: the enable appears one or more cycles early or late against the 2^c-tick boundary, or it survives a dropped request. A bad fault flag shows up on irq_n one cycle after the causing edge, or as an interrupt that fails to release after the matching read. A bad flag can also show as a release that does not re-latch one edge later while undervoltage is still present. Configuration faults appear at once in the combinational read word and on force_pwm.

// File: rtl/pwr_seq_pkg.sv
// Shared constants for the regulator sequencer.
// Assumes a fixed 8-bit register word with the field layout below.
package pwr_seq_pkg;
    parameter int NCH_DEF  = 3;             // number of regulator channels
    parameter int DLY_W    = 3;             // width of a delay code
    parameter int DATA_W   = 8;             // register word width
    localparam int CNT_W   = 1 << DLY_W;    // holds 2^(2^DLY_W - 1)
    localparam int STAT_BIT = 0;
    localparam int DLY_LSB  = 1;
    localparam int MASK_BIT = DLY_LSB + DLY_W;
    localparam int MODE_BIT = MASK_BIT + 1;
endpackage

// File: rtl/pwr_seq_delay.sv
// Turn-on delay for one channel. Counts ticks while start is held and
// raises the enable once 2^code ticks have been seen; code 0 passes
// start straight through. Assumes tick is a single-cycle pulse.
module pwr_seq_delay
    import pwr_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             start,
    input  logic [DLY_W-1:0] code,
    output logic             en
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_inc;
    logic [CNT_W-1:0] target;
    logic             done_q;
    logic             zero_code;

    // Derive the tick target and the next count value.
    always_comb begin
        zero_code = (code == '0);
        target    = CNT_W'(1) << code;
        cnt_inc   = cnt_q + CNT_W'(1);
    end

    // Count ticks during a held request; freeze once the wait has elapsed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!start) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (zero_code) begin
            done_q <= 1'b1;
        end else if (tick && !done_q) begin
            cnt_q <= cnt_inc;
            if (cnt_inc >= target) begin
                done_q <= 1'b1;
            end
        end
    end

    // Enable drops with the request in the same cycle.
    assign en = start && (done_q || zero_code);

    // R2: a non-zero wait can only complete on a tick edge.
    p_done_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(done_q) && $past(code) != '0) |-> $past(tick));

    // R4: a dropped request wipes the pending count.
    p_drop_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/pwr_seq_fault.sv
// Fault latch for one channel. Sets on an unmasked undervoltage while
// enabled, clears on a status read. Assumes uv is already synchronous.
module pwr_seq_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic uv,
    input  logic en,
    input  logic mask_en,
    input  logic rd_clr,
    output logic flag,
    output logic ok
);
    logic flag_q;

    // Live power-good: regulator on and above threshold.
    assign ok = en && !uv;

    // Latch the fault; a status read wins over a new set at the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (rd_clr) begin
            flag_q <= 1'b0;
        end else if (uv && en && mask_en) begin
            flag_q <= 1'b1;
        end
    end

    assign flag = flag_q;

    // R5: a flag only rises with an unmasked fault on an enabled channel.
    p_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(uv && en && mask_en));

    // R7: the status read releases the flag at the next edge.
    p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_clr |=> !flag_q);
endmodule

// File: rtl/pwr_seq_regs.sv
// Per-channel configuration words, write decode, read mux and the
// read-clear strobes. Unmapped addresses read zero and ignore writes.
module pwr_seq_regs
    import pwr_seq_pkg::*;
#(
    parameter int NCH    = NCH_DEF,
    parameter int ADDR_W = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [ADDR_W-1:0]         wr_addr,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic                      rd_en,
    input  logic [ADDR_W-1:0]         rd_addr,
    input  logic [NCH-1:0]            ok,
    output logic [NCH-1:0][DLY_W-1:0] dly,
    output logic [NCH-1:0]            mask_en,
    output logic [NCH-1:0]            mode,
    output logic [NCH-1:0]            rd_clr,
    output logic [DATA_W-1:0]         rd_data
);
    logic [NCH-1:0][DLY_W-1:0] dly_q;
    logic [NCH-1:0]            mask_q;
    logic [NCH-1:0]            mode_q;
    logic                      unused_bits;

    assign unused_bits = ^{wr_data[STAT_BIT], wr_data[DATA_W-1:MODE_BIT+1]};

    // Store the writable fields of the addressed channel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dly_q  <= '0;
            mask_q <= '0;
            mode_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NCH; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    dly_q[i]  <= wr_data[DLY_LSB +: DLY_W];
                    mask_q[i] <= wr_data[MASK_BIT];
                    mode_q[i] <= wr_data[MODE_BIT];
                end
            end
        end
    end

    // Assemble the word for the read address and decode the clear strobes.
    always_comb begin
        rd_data = '0;
        rd_clr  = '0;
        for (int i = 0; i < NCH; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data[STAT_BIT]           = ok[i];
                rd_data[DLY_LSB +: DLY_W]   = dly_q[i];
                rd_data[MASK_BIT]           = mask_q[i];
                rd_data[MODE_BIT]           = mode_q[i];
                rd_clr[i]                   = rd_en;
            end
        end
    end

    assign dly     = dly_q;
    assign mask_en = mask_q;
    assign mode    = mode_q;

    // R9: a write to a channel lands in its mask and mode fields.
    for (genvar g = 0; g < NCH; g++) begin : g_chk
        p_write_lands_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_addr == ADDR_W'(g)) |=>
            (mask_q[g] == $past(wr_data[MASK_BIT]) &&
             mode_q[g] == $past(wr_data[MODE_BIT])));
    end
endmodule

// File: rtl/pwr_seq_irq_ctrl.sv
// Top: turn-on delay per channel, fault latch per channel, register
// port, and the shared active-low interrupt. All inputs are assumed
// synchronous to clk.
module pwr_seq_irq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NCH = NCH_DEF,
    localparam int ADDR_W = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic [NCH-1:0]    start_req,
    input  logic [NCH-1:0]    uv_flag,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NCH-1:0]    reg_en,
    output logic [NCH-1:0]    force_pwm,
    output logic              irq_n
);
    logic [NCH-1:0][DLY_W-1:0] dly;
    logic [NCH-1:0]            mask_en;
    logic [NCH-1:0]            mode;
    logic [NCH-1:0]            rd_clr;
    logic [NCH-1:0]            ok;
    logic [NCH-1:0]            flag;

    pwr_seq_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_en   (rd_en),
        .rd_addr (rd_addr),
        .ok      (ok),
        .dly     (dly),
        .mask_en (mask_en),
        .mode    (mode),
        .rd_clr  (rd_clr),
        .rd_data (rd_data)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        pwr_seq_delay u_dly (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick_ms),
            .start (start_req[g]),
            .code  (dly[g]),
            .en    (reg_en[g])
        );
        pwr_seq_fault u_flt (
            .clk     (clk),
            .rst_n   (rst_n),
            .uv      (uv_flag[g]),
            .en      (reg_en[g]),
            .mask_en (mask_en[g]),
            .rd_clr  (rd_clr[g]),
            .flag    (flag[g]),
            .ok      (ok[g])
        );
    end

    // Combine latched faults into the shared interrupt; pass the mode out.
    assign irq_n     = ~|flag;
    assign force_pwm = mode;

    // R6: the interrupt falls only after an unmasked fault on an enabled channel.
    p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $past(|(uv_flag & reg_en & mask_en)));

    // R7: the interrupt releases only after a status read.
    p_irq_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_n) |-> $past(rd_en));
endmodule

// File: tb/sim_pwr_seq_irq_ctrl.sv
// Self-checking bench: directed corners followed by seeded random traffic,
// compared every cycle against a behavioural model written from the brief.
module sim_pwr_seq_irq_ctrl;
    localparam int NCH = 3;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_ms;
    logic [2:0] start_req, uv_flag;
    logic       wr_en, rd_en;
    logic [1:0] wr_addr, rd_addr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [2:0] reg_en, force_pwm;
    logic       irq_n;

    always #5 clk = ~clk;

    pwr_seq_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .start_req(start_req),
        .uv_flag(uv_flag), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .reg_en(reg_en),
        .force_pwm(force_pwm), .irq_n(irq_n)
    );

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    int m_cnt [NCH];
    bit m_done[NCH];
    bit m_flag[NCH];
    int m_dly [NCH];
    bit m_mask[NCH];
    bit m_mode[NCH];

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic bit exp_en(int i);
        return start_req[i] && (m_done[i] || m_dly[i] == 0);
    endfunction

    function automatic logic [7:0] exp_rd(int a);
        if (a >= NCH) return 8'h00;
        return {2'b00, m_mode[a], m_mask[a], 3'(m_dly[a]), exp_en(a) && !uv_flag[a]};
    endfunction

    function automatic bit exp_irq_n();
        bit any = 0;
        for (int i = 0; i < NCH; i++) any |= m_flag[i];
        return !any;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < NCH; i++) begin
            m_cnt[i] = 0; m_done[i] = 0; m_flag[i] = 0;
            m_dly[i] = 0; m_mask[i] = 0; m_mode[i] = 0;
        end
    endtask

    // One clock: compare outputs mid-cycle, then advance the model at the edge.
    task automatic step();
        bit en_now[NCH];
        #1;
        if (rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                check("R2 R3 R4 enable", int'(reg_en[i]), int'(exp_en(i)));
                check("R10 mode out", int'(force_pwm[i]), int'(m_mode[i]));
            end
            check("R5 R6 R7 irq_n", int'(irq_n), int'(exp_irq_n()));
            check("R8 R9 read word", int'(rd_data), int'(exp_rd(int'(rd_addr))));
        end
        for (int i = 0; i < NCH; i++) en_now[i] = exp_en(i);
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            model_reset();
        end else begin
            for (int i = 0; i < NCH; i++) begin
                if (!start_req[i]) begin
                    m_cnt[i] = 0; m_done[i] = 0;
                end else if (m_dly[i] == 0) begin
                    m_done[i] = 1;
                end else if (tick_ms && !m_done[i]) begin
                    m_cnt[i]++;
                    if (m_cnt[i] >= (1 << m_dly[i])) m_done[i] = 1;
                end
                if (rd_en && int'(rd_addr) == i) m_flag[i] = 0;
                else if (uv_flag[i] && en_now[i] && m_mask[i]) m_flag[i] = 1;
            end
            if (wr_en && int'(wr_addr) < NCH) begin
                m_dly[wr_addr]  = int'(wr_data[3:1]);
                m_mask[wr_addr] = wr_data[4];
                m_mode[wr_addr] = wr_data[5];
            end
        end
        @(negedge clk);
        wr_en = 0; rd_en = 0;
    endtask

    task automatic write(int a, logic [7:0] d);
        wr_en = 1; wr_addr = 2'(a); wr_data = d;
        step();
    endtask

    task automatic read(int a);
        rd_en = 1; rd_addr = 2'(a);
        step();
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        if (cyc > 200000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog (all R): actual %0d cycles expected below 200000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0c1a));
        rst_n = 0; tick_ms = 0; start_req = '0; uv_flag = '0;
        wr_en = 0; rd_en = 0; wr_addr = '0; rd_addr = '0; wr_data = '0;
        model_reset();
        @(negedge clk);
        repeat (3) step();
        rst_n = 1;
        #1;
        // R1: reset state at the ports.
        check("R1 reg_en", int'(reg_en), 0);
        check("R1 irq_n", int'(irq_n), 1);
        check("R1 force_pwm", int'(force_pwm), 0);
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a); #1;
            check("R1 read word", int'(rd_data), 0);
        end
        @(negedge clk);

        // Configure: ch0 code0 mask mode, ch1 code2 mask, ch2 code7 no mask.
        write(0, 8'h31); write(1, 8'h14); write(2, 8'h0E);
        write(3, 8'h3F);                                  // R9: ignored
        rd_addr = 2'd3; step();

        // R3/R2: start all; ch0 at once, ch1 after 4 ticks, ch2 after 128.
        start_req = 3'b111; tick_ms = 1;
        rd_addr = 2'd1;
        repeat (3) step();
        // R4: drop ch1 mid-wait and restart; full wait again.
        start_req[1] = 0; step();
        check("R4 dropped enable", int'(reg_en[1]), 0);
        start_req[1] = 1;
        repeat (140) step();
        check("R2 long wait done", int'(reg_en[2]), 1);
        tick_ms = 0;

        // R5/R7: fault on ch1 (masked in), read while still low re-latches.
        uv_flag[1] = 1; step(); step();
        read(1);
        step();
        uv_flag[1] = 0; read(1); step();
        // R5: unmasked-off channel ch2 never raises the interrupt.
        uv_flag[2] = 1; repeat (3) step();
        check("R5 masked channel irq_n", int'(irq_n), 1);
        uv_flag[2] = 0;
        // R5: disabled channel ignored.
        start_req[0] = 0; uv_flag[0] = 1; repeat (2) step();
        check("R5 disabled channel irq_n", int'(irq_n), 1);
        uv_flag[0] = 0; start_req[0] = 1;
        // R6 R7: two channels faulting, reads release one at a time.
        uv_flag = 3'b011; step(); uv_flag = 0; step();
        read(0); check("R6 one flag left", int'(irq_n), 0);
        read(1); step();

        // Random traffic.
        for (int n = 0; n < 6000; n++) begin
            tick_ms = ($urandom_range(0, 2) == 0);
            for (int i = 0; i < NCH; i++) begin
                if ($urandom_range(0, 63) == 0) start_req[i] = !start_req[i];
                if ($urandom_range(0, 15) == 0) uv_flag[i] = !uv_flag[i];
            end
            rd_addr = 2'($urandom_range(0, 3));
            rd_en   = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 29) == 0) begin
                wr_en = 1; wr_addr = 2'($urandom_range(0, 3));
                wr_data = 8'($urandom_range(0, 255));
                if ($urandom_range(0, 1) == 0) wr_data[3:1] = 3'($urandom_range(0, 3));
            end
            step();
        end

        summary();
        $finish;
    end
endmodule